// File: doc/BRIEF.md
# Partitioned Serial Symmetric FIR Filter

This block filters a stream of 12-bit signed samples with a symmetric FIR response. Because the impulse response is mirrored, each pair of taps that share a coefficient is summed before it is multiplied. The filter then works on the unique coefficients only, called the effective length. These tap pairs are divided into contiguous groups, one group per partition. Each partition owns one multiply-accumulate unit and the multiplexer that feeds it. Every partition takes one tap pair of its group per clock. All partitions run side by side and share one step counter.

The group sizes come from a packed parameter vector with one 8-bit field per partition, partition 0 in the least significant field. The largest group sets how many MAC clocks each sample costs. A partition with a smaller group stops adding once its group is done and keeps its value. When the longest partition has finished, an adder tree sums all partition results. The sum is rounded, saturated and registered as the output, and a one-cycle valid pulse goes with it. At elaboration the block refuses a vector whose field sum differs from the effective length, or that holds an empty group.

A user picks the vector to balance multipliers against clocks per sample. A sample can be offered in any idle cycle or on the cycle the previous result is written. A new sample may therefore be accepted every largest-group-plus-one clocks.

Top module: `firPartSerial`

## Requirements
- R1: With x[0] the newest accepted sample, x[k] the one accepted k samples earlier (zero before any sample), and N taps, the exact result is S = sum over i from 0 to ceil(N/2)-1 of h[i]*(x[i] + x[N-1-i]). The second term is omitted when i = N-1-i. h[i] is the signed COEF_W-bit field i of COEF_VEC, field 0 in the least significant bits.
- R2: The effective length ceil(N/2) is split into contiguous groups. Partition p takes its group size from field p (bits 8p+7..8p) of PART_VEC and starts right after the groups of partitions 0..p-1. The result equals R1 for every input pattern.
- R3: dataOut is updated and outValid is high for exactly one cycle, MAXP+1 clock edges after the edge that accepts a sample. MAXP is the largest group size.
- R4: A partition whose group is smaller than MAXP holds its accumulated value unchanged from its last tap until the result is written, so its taps are counted exactly once.
- R5: Rounding is half toward plus infinity. The output is floor((S + 2^(COEF_W-2)) / 2^(COEF_W-1)), so S/2048 = 37.5 gives 38 and -37.5 gives -37.
- R6: A rounded value above 2047 yields 2047 and one below -2048 yields -2048.
- R7: A sample is accepted when inValid is high in an idle cycle or in the result cycle. inValid during the MAXP cycles of tap processing is ignored and does not enter the sample history.
- R8: Reset clears the sample history to zero and drives outValid low and dataOut to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Offers dataIn as a new sample |
| dataIn | input | DATA_W (12) | Signed input sample |
| outValid | output | 1 | One-cycle strobe marking a new result |
| dataOut | output | DATA_W (12) | Rounded, saturated filter output |

## Verification
Each partition starts from its own base in the coefficient set. A wrong base or group size therefore moves or doubles a coefficient, and this shows in the impulse response within ten samples. An accumulator that keeps adding past its group, or that loses its value, corrupts the first result after an impulse reaches that group, at MAXP+1 edges. A step counter or state error shows as a result that arrives late, early or twice. A shift of the history during a busy cycle shows as shifted outputs on the next accepted sample. Full-scale steps and half-way products place the rounding and clipping edges at the output directly.

// File: rtl/firPartPkg.sv
package firPartPkg;

  localparam int FIELD_W = 8;
  localparam int VEC_MAX = 256;

  typedef struct packed {
    logic load;   // accept a sample into the history
    logic macEn;  // one tap-pair step for every partition
    logic first;  // step 0: accumulators load instead of add
    logic emit;   // write the combined result to the output
  } firStrobe_t;

  function automatic int partSize(input logic [VEC_MAX-1:0] vec, input int p);
    return int'(vec[p*FIELD_W +: FIELD_W]);
  endfunction

  function automatic int partBase(input logic [VEC_MAX-1:0] vec, input int p);
    int base;
    base = 0;
    for (int q = 0; q < p; q++) base += partSize(vec, q);
    return base;
  endfunction

  function automatic int partMax(input logic [VEC_MAX-1:0] vec, input int n);
    int m;
    m = 0;
    for (int q = 0; q < n; q++) if (partSize(vec, q) > m) m = partSize(vec, q);
    return m;
  endfunction

  function automatic int partMin(input logic [VEC_MAX-1:0] vec, input int n);
    int m;
    m = VEC_MAX;
    for (int q = 0; q < n; q++) if (partSize(vec, q) < m) m = partSize(vec, q);
    return m;
  endfunction

endpackage

// File: rtl/firPartCtrl.sv
module firPartCtrl
  import firPartPkg::*;
#(
  parameter int MAX_PART = 3,
  parameter int CNT_W    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  output firStrobe_t       strobe,
  output logic [CNT_W-1:0] tapIdx
);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_EMIT} ctrlState_t;

  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(MAX_PART - 1);

  ctrlState_t state;
  logic       accept;

  assign accept = inValid && (state != ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      tapIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state  <= ST_RUN;
            tapIdx <= '0;
          end
        end
        ST_RUN: begin
          if (tapIdx == LAST_STEP) state <= ST_EMIT;
          else tapIdx <= tapIdx + 1'b1;
        end
        ST_EMIT: begin
          tapIdx <= '0;
          state  <= accept ? ST_RUN : ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.load  = accept;
    strobe.macEn = (state == ST_RUN);
    strobe.first = (state == ST_RUN) && (tapIdx == '0);
    strobe.emit  = (state == ST_EMIT);
  end

  // R2: the shared step never leaves the largest group
  assert_step_range_R2: assert property (@(posedge clk) disable iff (rst)
    strobe.macEn |-> (int'(tapIdx) < MAX_PART));

  // R7: an accepted sample is followed by step 0
  assert_start_R7: assert property (@(posedge clk) disable iff (rst)
    strobe.load |=> (strobe.macEn && strobe.first));

  // R3: the result write lasts a single cycle
  assert_emit_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    strobe.emit |=> !strobe.emit);

endmodule

// File: rtl/firPartTree.sv
module firPartTree #(
  parameter int ACC_W     = 29,
  parameter int NUM_PARTS = 2
) (
  input  logic signed [ACC_W-1:0] leaf [NUM_PARTS],
  output logic signed [ACC_W-1:0] total
);

  localparam int LEVELS = (NUM_PARTS > 1) ? $clog2(NUM_PARTS) : 0;
  localparam int LEAVES = 1 << LEVELS;

  logic signed [ACC_W-1:0] node [2*LEAVES-1];

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < NUM_PARTS) begin : g_used
      assign node[LEAVES-1+i] = leaf[i];
    end else begin : g_pad
      assign node[LEAVES-1+i] = '0;
    end
  end

  for (genvar i = 0; i < LEAVES - 1; i++) begin : g_add
    assign node[i] = node[2*i+1] + node[2*i+2];
  end

  assign total = node[0];

endmodule

// File: rtl/firPartData.sv
module firPartData
  import firPartPkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int COEF_W    = 12,
  parameter int NUM_TAPS  = 10,
  parameter int NUM_PARTS = 2,
  parameter logic [NUM_PARTS*FIELD_W-1:0] PART_VEC = 16'h0203,
  parameter logic [((NUM_TAPS+1)/2)*COEF_W-1:0] COEF_VEC = '0,
  parameter int CNT_W     = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  firStrobe_t               strobe,
  input  logic [CNT_W-1:0]         tapIdx,
  input  logic signed [DATA_W-1:0] dataIn,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] dataOut
);

  localparam int NUM_PAIRS = (NUM_TAPS + 1) / 2;
  localparam int PAIR_W    = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1;
  localparam int TAP_W     = (NUM_TAPS > 1) ? $clog2(NUM_TAPS) : 1;
  localparam int ACC_W     = DATA_W + COEF_W + PAIR_W + 2;
  localparam int FRAC      = COEF_W - 1;
  localparam logic [VEC_MAX-1:0] VEC_WIDE = VEC_MAX'(PART_VEC);
  localparam logic signed [ACC_W-1:0] OUT_MAX  = ACC_W'((1 <<< (DATA_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] OUT_MIN  = -ACC_W'(1 <<< (DATA_W - 1));
  localparam logic signed [ACC_W-1:0] ROUND_HALF = ACC_W'(1 <<< (FRAC - 1));

  logic signed [DATA_W-1:0] history [NUM_TAPS];
  logic signed [COEF_W-1:0] coefTab [NUM_PAIRS];
  logic signed [ACC_W-1:0]  partAcc [NUM_PARTS];
  logic signed [ACC_W-1:0]  treeSum;
  logic signed [ACC_W-1:0]  rounded;
  logic signed [DATA_W-1:0] clipped;

  // sample history, newest at index 0
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_TAPS; k++) history[k] <= '0;
    end else if (strobe.load) begin
      history[0] <= dataIn;
      for (int k = 1; k < NUM_TAPS; k++) history[k] <= history[k-1];
    end
  end

  for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_coef
    assign coefTab[i] = COEF_VEC[i*COEF_W +: COEF_W];
  end

  for (genvar p = 0; p < NUM_PARTS; p++) begin : g_part
    localparam int SIZE = partSize(VEC_WIDE, p);
    localparam int BASE = partBase(VEC_WIDE, p);

    logic                     inRange;
    logic [PAIR_W-1:0]        pairIdx;
    logic [TAP_W-1:0]         nearIdx;
    logic [TAP_W-1:0]         farIdx;
    logic signed [DATA_W:0]   preSum;
    logic signed [ACC_W-1:0]  product;
    logic signed [ACC_W-1:0]  acc;

    assign inRange = int'(tapIdx) < SIZE;

    // operand multiplexer: pick this partition's current tap pair
    always_comb begin
      pairIdx = PAIR_W'(BASE);
      if (inRange) pairIdx = PAIR_W'(BASE + int'(tapIdx));
      nearIdx = TAP_W'(pairIdx);
      farIdx  = TAP_W'(NUM_TAPS - 1) - nearIdx;
      preSum  = {history[nearIdx][DATA_W-1], history[nearIdx]};
      if (farIdx != nearIdx)
        preSum = preSum + {history[farIdx][DATA_W-1], history[farIdx]};
      product = ACC_W'(preSum) * ACC_W'(coefTab[pairIdx]);
    end

    always_ff @(posedge clk) begin
      if (rst) acc <= '0;
      else if (strobe.macEn && inRange) acc <= strobe.first ? product : acc + product;
    end

    assign partAcc[p] = acc;

    // R4: past its group a partition keeps its sum
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
      (strobe.macEn && !strobe.first && !inRange) |=> $stable(acc));
  end

  firPartTree #(
    .ACC_W    (ACC_W),
    .NUM_PARTS(NUM_PARTS)
  ) u_tree (
    .leaf (partAcc),
    .total(treeSum)
  );

  always_comb begin
    rounded = (treeSum + ROUND_HALF) >>> FRAC;
    if (rounded > OUT_MAX)      clipped = OUT_MAX[DATA_W-1:0];
    else if (rounded < OUT_MIN) clipped = OUT_MIN[DATA_W-1:0];
    else                        clipped = rounded[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      dataOut  <= '0;
    end else begin
      outValid <= strobe.emit;
      if (strobe.emit) dataOut <= clipped;
    end
  end

  // R3: a result strobe always stands alone
  assert_out_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid);

  // R7: history moves only on accepted samples
  assert_history_R7: assert property (@(posedge clk) disable iff (rst)
    strobe.macEn |=> $stable(history[0]));

endmodule

// File: rtl/firPartSerial.sv
module firPartSerial
  import firPartPkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int COEF_W    = 12,
  parameter int NUM_TAPS  = 10,
  parameter int NUM_PARTS = 2,
  parameter logic [NUM_PARTS*FIELD_W-1:0] PART_VEC = 16'h0203,
  parameter logic [((NUM_TAPS+1)/2)*COEF_W-1:0] COEF_VEC =
    {12'd900, 12'd600, 12'd300, 12'd120, 12'hFD8}
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] dataIn,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] dataOut
);

  localparam int NUM_PAIRS = (NUM_TAPS + 1) / 2;
  localparam logic [VEC_MAX-1:0] VEC_WIDE = VEC_MAX'(PART_VEC);
  localparam int MAX_PART  = partMax(VEC_WIDE, NUM_PARTS);
  localparam int MIN_PART  = partMin(VEC_WIDE, NUM_PARTS);
  localparam int PART_SUM  = partBase(VEC_WIDE, NUM_PARTS);
  localparam int CNT_W     = (MAX_PART > 1) ? $clog2(MAX_PART) : 1;

  if (PART_SUM != NUM_PAIRS) begin : g_badSum
    $error("partition sizes must add up to the effective length");
  end
  if (MIN_PART < 1) begin : g_emptyPart
    $error("every partition needs at least one tap pair");
  end

  firStrobe_t       strobe;
  logic [CNT_W-1:0] tapIdx;

  firPartCtrl #(
    .MAX_PART(MAX_PART),
    .CNT_W   (CNT_W)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .inValid(inValid),
    .strobe (strobe),
    .tapIdx (tapIdx)
  );

  firPartData #(
    .DATA_W   (DATA_W),
    .COEF_W   (COEF_W),
    .NUM_TAPS (NUM_TAPS),
    .NUM_PARTS(NUM_PARTS),
    .PART_VEC (PART_VEC),
    .COEF_VEC (COEF_VEC),
    .CNT_W    (CNT_W)
  ) u_data (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .tapIdx  (tapIdx),
    .dataIn  (dataIn),
    .outValid(outValid),
    .dataOut (dataOut)
  );

endmodule

// File: tb/tb_firPartSerial.sv
module tb_firPartSerial;

  localparam int NTAPS = 10;
  localparam int NPAIR = 5;
  localparam int MAXP  = 3;
  localparam int HALFP = 2;   // 4 ns period, 250 MHz

  typedef struct {
    int    value;
    int    due;
    string tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic signed [11:0] dataIn = '0;
  logic outValid;
  logic signed [11:0] dataOut;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int hist [NTAPS];
  int coef [NPAIR] = '{-40, 120, 300, 600, 900};
  expItem_t expQ [$];

  firPartSerial dut (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .dataIn  (dataIn),
    .outValid(outValid),
    .dataOut (dataOut)
  );

  always #HALFP clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int refModel();
    longint s, r;
    s = 0;
    for (int i = 0; i < NPAIR; i++) begin
      if (i == NTAPS - 1 - i) s += longint'(coef[i]) * hist[i];
      else s += longint'(coef[i]) * (hist[i] + hist[NTAPS-1-i]);
    end
    r = (s + 1024) >>> 11;          // R5 rounding
    if (r > 2047) r = 2047;         // R6 clipping
    if (r < -2048) r = -2048;
    return int'(r);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // driver: called at a falling edge, returns at a falling edge
  task automatic send(input int x, input string tag, input int gap);
    expItem_t it;
    dataIn  = 12'(x);
    inValid = 1'b1;
    for (int k = NTAPS - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = x;
    it.value = refModel();
    it.due   = cyc + 1 + MAXP + 1;   // R3 latency from the accepting edge
    it.tag   = tag;
    expQ.push_back(it);
    @(negedge clk);
    inValid = 1'b0;
    repeat (gap - 1) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (expQ.size() > 0 && expQ[0].due < cyc) begin
        check(1'b0, {expQ[0].tag, " missing result"}, cyc, expQ[0].due);
        void'(expQ.pop_front());
      end
      if (outValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R3 unexpected result", int'(dataOut), 0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(int'(dataOut) == it.value, it.tag, int'(dataOut), it.value);
          check(cyc == it.due, {it.tag, " R3 timing"}, cyc, it.due);
        end
      end
    end
  end

  task automatic finishRun();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    finishRun();
  end

  initial begin
    for (int k = 0; k < NTAPS; k++) hist[k] = 0;
    repeat (3) @(negedge clk);
    // R8: reset state
    check(outValid == 1'b0, "R8 outValid in reset", int'(outValid), 0);
    check(dataOut == 12'sd0, "R8 dataOut in reset", int'(dataOut), 0);
    rst = 1'b0;
    @(negedge clk);

    // R1, R2, R4: impulse walks through every tap, both partitions
    send(1000, "R2_R4 impulse", 4);
    for (int i = 0; i < NTAPS; i++) send(0, "R2_R4 impulse", 4);

    // R5: half-way products, positive and negative
    send(128, "R5 round pos", 4);
    for (int i = 0; i < 3; i++) send(0, "R5 round", 4);
    send(-128, "R5 round neg", 4);
    for (int i = 0; i < NTAPS; i++) send(0, "R5 round", 5);

    // R6: full-scale steps
    for (int i = 0; i < NTAPS; i++) send(2047, "R6 clip high", 4);
    for (int i = 0; i < NTAPS; i++) send(-2048, "R6 clip low", 4);

    // R1: mixed values and spacings
    for (int i = 0; i < 24; i++) send(((i * 737 + 91) % 4096) - 2048, "R1 mixed", 4 + (i % 4));

    // R7: inValid held while taps are processed is ignored
    for (int i = 0; i < 6; i++) begin
      send(300 * i - 700, "R7 busy", 1);
      dataIn  = 12'sd1999;
      inValid = 1'b1;
      repeat (MAXP) @(negedge clk);
      inValid = 1'b0;
    end
    for (int i = 0; i < NTAPS; i++) send(i * 50, "R7 after busy", 4);

    // R8: reset mid-stream clears the history
    repeat (8) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(outValid == 1'b0, "R8 outValid after reset", int'(outValid), 0);
    check(dataOut == 12'sd0, "R8 dataOut after reset", int'(dataOut), 0);
    for (int k = 0; k < NTAPS; k++) hist[k] = 0;
    rst = 1'b0;
    @(negedge clk);
    send(500, "R8 fresh history", 4);
    for (int i = 0; i < NTAPS; i++) send(0, "R8 fresh history", 4);

    repeat (10) @(negedge clk);
    check(expQ.size() == 0, "R3 results outstanding", expQ.size(), 0);
    finishRun();
  end

endmodule